// File: doc/BRIEF.md
# Condition Flag and Predication Unit

This block keeps the four processor status flags (negative, zero, carry, overflow) and decides, from the 4-bit condition code carried in the top bits of each instruction, whether the instruction in flight is allowed to take effect. The same decision gates conditional branches and predicated ordinary operations, so the rest of the pipeline only has to look at one enable.

When an instruction that asks for a flag update passes its own condition, the unit captures new flags at the next clock edge: negative and zero come from the ALU result, and carry and overflow come straight from the ALU. A compare updates the flags the same way but never asks for its result to be written back. Relational conditions read the same stored flags in two ways: unsigned tests use carry and zero, and signed tests use negative, overflow and zero.

Top module: `cond_flag_unit`

## Requirements
- R1: While reset is low and just after it is released, the flag bus reads 0000. Bit positions on the flag bus are negative=3, zero=2, carry=1, overflow=0.
- R2: When the condition passes and setFlags or cmpStrobe is high, the flag bus after the next rising edge equals {result MSB, result==0, aluCarry, aluOverflow}.
- R3: When neither setFlags nor cmpStrobe is high, the flags keep their value across the edge.
- R4: When the condition fails, the flags keep their value even if a strobe is high, and execEn and resultWe are low.
- R5: resultWe equals execEn while cmpStrobe is low and is 0 while cmpStrobe is high, so a compare only updates flags.
- R6: Condition 14 always passes and condition 15 never passes, whatever the flags are.
- R7: Condition 0 passes when zero is set, and condition 1 passes when zero is clear.
- R8: Condition 4 passes on negative set and 5 on negative clear. Condition 6 passes on overflow set and 7 on overflow clear.
- R9: The unsigned tests are: 2 (higher or same) passes on C, 3 (lower) on !C, 8 (higher) on C&!Z, and 9 (lower or same) on !C|Z.
- R10: The signed tests are: 10 (>=) passes on N==V, 11 (<) on N!=V, 12 (>) on !Z&(N==V), and 13 (<=) on Z|(N!=V).
- R11: After a compare of all-ones with one (carry 1 = no borrow, overflow 0), condition 3 fails and condition 11 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| condField | input | 4 | Condition code of the current instruction |
| aluResult | input | DATA_W | ALU result of the current instruction |
| aluCarry | input | 1 | ALU carry-out (for subtraction: 1 = no borrow) |
| aluOverflow | input | 1 | ALU signed overflow |
| setFlags | input | 1 | The instruction asks for a flag update |
| cmpStrobe | input | 1 | The instruction is a compare |
| flags | output | 4 | Stored flags {N, Z, C, V} |
| execEn | output | 1 | The condition passed, so the instruction executes |
| resultWe | output | 1 | Write enable for the result register |

## Verification
The hardest cases to reach are the flag combinations that only particular ALU outcomes produce, such as negative and overflow set together while zero is clear. These decide how the signed and unsigned tests differ. The stimulus loads every legal {N,Z,C,V} combination through a flag-setting step and then sweeps all sixteen condition codes with no strobes, so each combination is checked without disturbing it. Compares with operands chosen in the bench, including all-ones against one and the most negative value against one, tie the relational results to real subtraction outcomes.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef enum logic [3:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_HS = 4'd2,  CC_LO = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } condCode_e;

  typedef struct packed {
    logic capture;
    logic writeResult;
  } cfuStrobes_t;
endpackage

// File: rtl/cfu_ctrl.sv
module cfu_ctrl
  import cfu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        condField,
  input  logic [FLAG_W-1:0] curFlags,
  input  logic              setFlags,
  input  logic              cmpStrobe,
  output logic              execEn,
  output cfuStrobes_t       strobes
);
  localparam int PAIRS = 8;

  logic n, z, c, v;
  logic [PAIRS-1:0] basePass;
  logic             pass;

  assign n = curFlags[FLAG_N];
  assign z = curFlags[FLAG_Z];
  assign c = curFlags[FLAG_C];
  assign v = curFlags[FLAG_V];

  // Conditions come in complementary pairs; the low bit inverts the pair's base test.
  always_comb begin
    basePass[0] = z;
    basePass[1] = c;
    basePass[2] = n;
    basePass[3] = v;
    basePass[4] = c & ~z;
    basePass[5] = (n == v);
    basePass[6] = ~z & (n == v);
    basePass[7] = 1'b1;
  end

  assign pass   = basePass[condField[3:1]] ^ condField[0];
  assign execEn = pass;

  always_comb begin
    strobes.capture     = pass & (setFlags | cmpStrobe);
    strobes.writeResult = pass & ~cmpStrobe;
  end

  AST_ALWAYS_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    (condField == CC_AL) |-> execEn); // R6
  AST_NEVER_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    (condField == CC_NV) |-> !execEn); // R6
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    cmpStrobe |-> !strobes.writeResult); // R5
  AST_FAIL_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |-> !strobes.capture); // R4
  AST_EQ_FROM_Z: assert property (@(posedge clk) disable iff (!rstN)
    (condField == CC_EQ) |-> (execEn == curFlags[FLAG_Z])); // R7
endmodule

// File: rtl/cfu_datapath.sv
module cfu_datapath
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  input  cfuStrobes_t       strobes,
  output logic [FLAG_W-1:0] flagReg
);
  logic [FLAG_W-1:0] nextFlags;

  always_comb begin
    nextFlags         = '0;
    nextFlags[FLAG_N] = aluResult[DATA_W-1];
    nextFlags[FLAG_Z] = (aluResult == '0);
    nextFlags[FLAG_C] = aluCarry;
    nextFlags[FLAG_V] = aluOverflow;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                flagReg <= '0;
    else if (strobes.capture) flagReg <= nextFlags;
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> $stable(flagReg)); // R3
  AST_ZERO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.capture && aluResult == '0) |=> flagReg[FLAG_Z]); // R2
  AST_N_ZERO_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(flagReg[FLAG_N] && flagReg[FLAG_Z])); // R2
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        condField,
  input  logic [DATA_W-1:0] aluResult,
  input  logic              aluCarry,
  input  logic              aluOverflow,
  input  logic              setFlags,
  input  logic              cmpStrobe,
  output logic [3:0]        flags,
  output logic              execEn,
  output logic              resultWe
);
  cfuStrobes_t       strobes;
  logic [FLAG_W-1:0] flagReg;

  cfu_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .condField(condField), .curFlags(flagReg),
    .setFlags(setFlags), .cmpStrobe(cmpStrobe), .execEn(execEn), .strobes(strobes)
  );

  cfu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .aluResult(aluResult), .aluCarry(aluCarry),
    .aluOverflow(aluOverflow), .strobes(strobes), .flagReg(flagReg)
  );

  assign flags    = flagReg;
  assign resultWe = strobes.writeResult;
endmodule

// File: tb/cond_flag_unit_tb.sv
module cond_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  condField = 4'd0;
  logic [31:0] aluResult = '0;
  logic        aluCarry = 1'b0, aluOverflow = 1'b0, setFlags = 1'b0, cmpStrobe = 1'b0;
  logic [3:0]  flags;
  logic        execEn, resultWe;

  int checks = 0;
  int errors = 0;
  logic [3:0] mFlags = 4'b0000;

  typedef struct {
    logic       exec;
    logic       we;
    logic [3:0] fl;
    string      tag;
  } item_t;
  item_t sbq[$];

  always #10 clk = ~clk;

  cond_flag_unit u_dut (
    .clk(clk), .rstN(rstN), .condField(condField), .aluResult(aluResult),
    .aluCarry(aluCarry), .aluOverflow(aluOverflow), .setFlags(setFlags),
    .cmpStrobe(cmpStrobe), .flags(flags), .execEn(execEn), .resultWe(resultWe)
  );

  function automatic logic refPass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    n = f[3]; z = f[2]; c = f[1]; v = f[0];
    case (cc)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return c;
      4'd3:  return !c;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return c && !z;
      4'd9:  return !c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tagOf(input logic [3:0] cc);
    if (cc <= 4'd1) return "R7";
    if (cc == 4'd2 || cc == 4'd3 || cc == 4'd8 || cc == 4'd9) return "R9";
    if (cc >= 4'd4 && cc <= 4'd7) return "R8";
    if (cc >= 4'd10 && cc <= 4'd13) return "R10";
    return "R6";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: applies one instruction per cycle and queues the expected outcome.
  task automatic step(input logic [3:0] cc, input logic [31:0] res, input logic c,
                      input logic v, input logic sf, input logic cmp, input string tag);
    item_t it;
    @(negedge clk);
    condField = cc; aluResult = res; aluCarry = c; aluOverflow = v;
    setFlags = sf; cmpStrobe = cmp;
    it.exec = refPass(cc, mFlags);
    it.we   = it.exec && !cmp;
    if (it.exec && (sf || cmp)) mFlags = {res[31], (res == 32'd0), c, v};
    it.fl  = mFlags;
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic doCmp(input logic [31:0] a, input logic [31:0] b, input logic [3:0] cc,
                       input string tag);
    logic [31:0] d;
    d = a - b;
    step(cc, d, (a >= b), (a[31] != b[31]) && (d[31] != a[31]), 1'b0, 1'b1, tag);
  endtask

  task automatic probe(input logic [3:0] cc, input string tag);
    step(cc, 32'h5A5A_0001, 1'b1, 1'b1, 1'b0, 1'b0, tag);
  endtask

  // Monitor: observes the outputs mid-cycle and after the edge, pops and compares.
  initial begin
    item_t it;
    logic obsExec, obsWe;
    forever begin
      @(negedge clk); #5;
      obsExec = execEn; obsWe = resultWe;
      @(posedge clk); #5;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check({it.tag, " execEn"}, {31'd0, obsExec}, {31'd0, it.exec});
        check({it.tag, " resultWe"}, {31'd0, obsWe}, {31'd0, it.we});
        check({it.tag, " flags"}, {28'd0, flags}, {28'd0, it.fl});
      end
    end
  end

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flags in reset", {28'd0, flags}, 32'd0);
    rstN = 1'b1;
    @(negedge clk); #5;
    check("R1 flags after reset", {28'd0, flags}, 32'd0);

    // R11: all-ones compared with one
    doCmp(32'hFFFF_FFFF, 32'd1, 4'd14, "R11 cmp");
    probe(4'd3,  "R11 LO");
    probe(4'd11, "R11 LT");
    probe(4'd2,  "R9 HS");
    probe(4'd10, "R10 GE");

    // R2: flag setting from a zero result
    step(4'd14, 32'd0, 1'b1, 1'b0, 1'b1, 1'b0, "R2 set zero");
    probe(4'd0, "R7 EQ");
    probe(4'd1, "R7 NE");
    // R3: no strobe, flags hold
    step(4'd14, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b0, "R3 hold");
    // R4: failing condition with strobes high
    step(4'd1, 32'h8000_0000, 1'b0, 1'b1, 1'b1, 1'b0, "R4 sf fail");
    step(4'd1, 32'h8000_0000, 1'b0, 1'b1, 1'b0, 1'b1, "R4 cmp fail");
    // R6: never-execute with a strobe
    step(4'd15, 32'h0000_0007, 1'b0, 1'b1, 1'b1, 1'b0, "R6 NV");
    // R5: compare does not write, set-flags does
    doCmp(32'd7, 32'd7, 4'd14, "R5 cmp we");
    step(4'd0, 32'h8000_0001, 1'b0, 1'b1, 1'b1, 1'b0, "R5 sf we");
    probe(4'd4, "R8 MI");
    probe(4'd6, "R8 VS");
    probe(4'd5, "R8 PL");

    // Signed and unsigned relations from real compares
    doCmp(32'd5, 32'd7, 4'd14, "R2 cmp 5-7");
    probe(4'd11, "R10 LT");
    probe(4'd3,  "R9 LO");
    doCmp(32'h8000_0000, 32'd1, 4'd14, "R2 cmp min-1");
    probe(4'd10, "R10 GE ovf");
    probe(4'd8,  "R9 HI");
    doCmp(32'd7, 32'd5, 4'd14, "R2 cmp 7-5");
    probe(4'd12, "R10 GT");
    probe(4'd13, "R10 LE");

    // Sweep every legal flag pattern against every condition code
    for (int f = 0; f < 16; f++) begin
      logic [3:0] fv;
      logic [31:0] r;
      fv = f[3:0];
      if (fv[3] && fv[2]) continue;
      r = fv[2] ? 32'd0 : (fv[3] ? 32'hC000_0000 : 32'd42);
      step(4'd14, r, fv[1], fv[0], 1'b1, 1'b0, "R2 load");
      for (int cc = 0; cc < 16; cc++) probe(cc[3:0], tagOf(cc[3:0]));
    end

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule